// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block turns a fast peripheral clock into the SCL waveform of an I2C master. The SCL period is set by a 12-bit divider value. Three ratio schemes are available. Standard mode gives equal low and high phases. Fast mode gives either a 2:1 or a 16:9 low-to-high ratio. The same fast scheme also covers the faster bus grades. Small divider values are clamped to a safe floor for each mode.

The generator drives SCL as an open-drain line. It only pulls the wire low, and it releases the wire for the high phase. After each release it watches the real bus level, through a short synchronizer. This lets a slave stretch the clock by holding SCL low. It also lets the master follow another master that pulls the line low early. A rise-time allowance sets how many released-but-still-low cycles still count as high time. The block gives two one-cycle strobes to the bit engine that sits next to it. One marks the middle of each high phase, where SDA is sampled. The other marks a quarter of the way into each low phase, where SDA may change.

All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake.

Top module: `scl_clock_gen`

## Requirements
- R1: In standard mode (`fast_mode`=0), with no stretching and `rise_allow` at least the synchronizer depth, the low phase and the high phase each last D cycles. D is the effective divider, so the SCL period is 2·D.
- R2: In fast mode with `duty_sel`=0, the low phase lasts 2·D cycles and the high phase lasts D cycles.
- R3: In fast mode with `duty_sel`=1, the low phase lasts 16·D cycles and the high phase lasts 9·D cycles.
- R4: In standard mode, a `divider` value below 4 acts as 4.
- R5: In fast mode, a `divider` value of 0 acts as 1.
- R6: If SCL stays low after release, the high phase is stretched. Its count does not advance while the synchronized line is low and the rise allowance is used up.
- R7: While SCL is released, up to `rise_allow` cycles in which the synchronized line still reads low are credited to the high phase. With `rise_allow`=0, the high phase is therefore D plus the synchronizer depth (2 by default), counted from release.
- R8: If the synchronized line has been seen high during a high phase and then reads low, the high phase ends at once and a low phase starts. This keeps the block in step with another master.
- R9: `sample_strobe` pulses for one cycle per high phase, only while SCL is released. It fires on the advancing cycle whose phase count equals floor(H/2), where H is the high length.
- R10: `update_strobe` pulses for one cycle per low phase, only while `scl_drive_low`=1. It fires at low-phase cycle index floor(L/4), counted from 0, where L is the low length.
- R11: While `enable`=0, `scl_drive_low` is 0, both strobes are 0 and all counts clear. When the block is re-enabled, the first cycle is the start of a full-length low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run the generator; 0 releases SCL and clears state |
| fast_mode | input | 1 | 0 = standard ratio scheme, 1 = fast ratio scheme |
| duty_sel | input | 1 | In fast mode: 0 = 2:1, 1 = 16:9 low-to-high |
| divider | input | DIV_W (12) | Period divider value |
| rise_allow | input | RISE_W (6) | Released-but-low cycles credited to the high phase |
| scl_in | input | 1 | Sensed SCL bus level |
| scl_drive_low | output | 1 | 1 = pull SCL low, 0 = release |
| sample_strobe | output | 1 | One-cycle pulse at mid high phase |
| update_strobe | output | 1 | One-cycle pulse at quarter low phase |

## Verification
The hardest cases are those where the bus level and the block's own drive disagree. One is a slave that holds SCL low right at the release edge. The other is another master that pulls SCL low partway through a high phase. Both depend on when that happens relative to the synchronizer delay and to the remaining rise allowance.

The bench models the bus as a wired AND of the generator's drive and a second, simulated device. It raises that device's hold on the exact falling clock edge where it sees the release, or a fixed number of cycles into an observed high phase. A behavioural cycle model then tracks every stretched and shortened phase on each clock.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic [1:0] {
    PH_OFF  = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;

  // floor of the divider in standard mode
  localparam int STD_MIN_DIV  = 4;
  // floor of the divider in fast modes
  localparam int FAST_MIN_DIV = 1;
  // extra length bits needed for the 16x low phase
  localparam int LEN_EXTRA    = 5;
endpackage

// File: rtl/scl_phase_len.sv
module scl_phase_len
  import scl_gen_pkg::*;
#(
  parameter int DIV_W = 12,
  parameter int LEN_W = DIV_W + LEN_EXTRA
) (
  input  logic             fast_mode,
  input  logic             duty_sel,
  input  logic [DIV_W-1:0] divider,
  output logic [LEN_W-1:0] low_len,
  output logic [LEN_W-1:0] high_len
);
  logic [DIV_W-1:0] div_eff;
  logic [LEN_W-1:0] unit;

  // per-mode clamp of the divider
  always_comb begin
    div_eff = divider;
    if (!fast_mode) begin
      if (divider < DIV_W'(STD_MIN_DIV)) div_eff = DIV_W'(STD_MIN_DIV);
    end else begin
      if (divider < DIV_W'(FAST_MIN_DIV)) div_eff = DIV_W'(FAST_MIN_DIV);
    end
  end

  assign unit = LEN_W'(div_eff);

  // ratio scheme selection
  always_comb begin
    if (!fast_mode) begin
      low_len  = unit;
      high_len = unit;
    end else if (!duty_sel) begin
      low_len  = unit << 1;
      high_len = unit;
    end else begin
      low_len  = unit << 4;
      high_len = (unit << 3) + unit;
    end
  end
endmodule

// File: rtl/scl_in_sync.sv
module scl_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign dout = din;
    end else begin : g_chain
      logic [STAGES-1:0] stage_q;
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
          always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[0] <= 1'b1;
            else        stage_q[0] <= din;
          end
        end else begin : g_next
          always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[i] <= 1'b1;
            else        stage_q[i] <= stage_q[i-1];
          end
        end
      end
      assign dout = stage_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_gen_pkg::*;
#(
  parameter int LEN_W  = 17,
  parameter int RISE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              scl_hi,
  input  logic [LEN_W-1:0]  low_len,
  input  logic [LEN_W-1:0]  high_len,
  input  logic [RISE_W-1:0] rise_allow,
  output logic              drive_low,
  output logic              sample_stb,
  output logic              update_stb
);
  scl_phase_e        phase_q;
  logic [LEN_W-1:0]  cnt_q;
  logic [RISE_W-1:0] rise_q;
  logic              seen_q;

  logic advance, sync_abort, low_last, high_last;

  assign advance    = scl_hi | (rise_q < rise_allow);
  assign sync_abort = seen_q & ~scl_hi;
  assign low_last   = cnt_q >= (low_len - LEN_W'(1));
  assign high_last  = cnt_q >= (high_len - LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_OFF;
      cnt_q   <= '0;
      rise_q  <= '0;
      seen_q  <= 1'b0;
    end else if (!enable) begin
      phase_q <= PH_OFF;
      cnt_q   <= '0;
      rise_q  <= '0;
      seen_q  <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_OFF: begin
          phase_q <= PH_LOW;
          cnt_q   <= '0;
        end
        PH_LOW: begin
          if (low_last) begin
            phase_q <= PH_HIGH;
            cnt_q   <= '0;
            rise_q  <= '0;
            seen_q  <= 1'b0;
          end else begin
            cnt_q <= cnt_q + LEN_W'(1);
          end
        end
        PH_HIGH: begin
          if (scl_hi) seen_q <= 1'b1;
          if (sync_abort) begin
            phase_q <= PH_LOW;
            cnt_q   <= '0;
          end else if (advance) begin
            if (!scl_hi) rise_q <= rise_q + RISE_W'(1);
            if (high_last) begin
              phase_q <= PH_LOW;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + LEN_W'(1);
            end
          end
        end
        default: phase_q <= PH_OFF;
      endcase
    end
  end

  assign drive_low  = (phase_q == PH_LOW);
  assign sample_stb = (phase_q == PH_HIGH) && !sync_abort && advance &&
                      (cnt_q == (high_len >> 1));
  assign update_stb = (phase_q == PH_LOW) && (cnt_q == (low_len >> 2));
endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen
  import scl_gen_pkg::*;
#(
  parameter int DIV_W       = 12,
  parameter int RISE_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              fast_mode,
  input  logic              duty_sel,
  input  logic [DIV_W-1:0]  divider,
  input  logic [RISE_W-1:0] rise_allow,
  input  logic              scl_in,
  output logic              scl_drive_low,
  output logic              sample_strobe,
  output logic              update_strobe
);
  localparam int LEN_W = DIV_W + LEN_EXTRA;

  logic [LEN_W-1:0] low_len, high_len;
  logic             scl_hi;

  scl_phase_len #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u_len (
    .fast_mode (fast_mode),
    .duty_sel  (duty_sel),
    .divider   (divider),
    .low_len   (low_len),
    .high_len  (high_len)
  );

  scl_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (scl_in),
    .dout  (scl_hi)
  );

  scl_phase_fsm #(.LEN_W(LEN_W), .RISE_W(RISE_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .scl_hi     (scl_hi),
    .low_len    (low_len),
    .high_len   (high_len),
    .rise_allow (rise_allow),
    .drive_low  (scl_drive_low),
    .sample_stb (sample_strobe),
    .update_stb (update_strobe)
  );
endmodule

// File: rtl/scl_clock_gen_checker.sv
module scl_clock_gen_checker (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic scl_drive_low,
  input logic sample_strobe,
  input logic update_strobe
);
  // R11: one cycle after enable drops, the line is released
  assert_release_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!scl_drive_low && !sample_strobe && !update_strobe));

  // R11: enabling starts with a low phase
  assert_start_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable) |=> scl_drive_low);

  // R9: sampling only happens while the line is released
  assert_sample_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |-> !scl_drive_low);

  // R10: update only happens while the line is pulled low
  assert_update_driven_R10: assert property (@(posedge clk) disable iff (!rst_n)
    update_strobe |-> scl_drive_low);

  // R9: a single sample pulse, never two in a row
  assert_sample_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |=> !sample_strobe);
endmodule

bind scl_clock_gen scl_clock_gen_checker u_chk (.*);

// File: tb/scl_clock_gen_bench.sv
`timescale 1ns/1ps
module scl_clock_gen_bench;
  localparam int DIV_W = 12;
  localparam int RISE_W = 6;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic fast_mode = 1'b0;
  logic duty_sel = 1'b0;
  logic [DIV_W-1:0] divider = '0;
  logic [RISE_W-1:0] rise_allow = '0;
  logic slave_hold = 1'b0;
  logic scl_in;
  logic scl_drive_low, sample_strobe, update_strobe;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign scl_in = ~scl_drive_low & ~slave_hold;

  scl_clock_gen #(.DIV_W(DIV_W), .RISE_W(RISE_W), .SYNC_STAGES(SYNC)) u_scl_clock_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .fast_mode(fast_mode),
    .duty_sel(duty_sel), .divider(divider), .rise_allow(rise_allow),
    .scl_in(scl_in), .scl_drive_low(scl_drive_low),
    .sample_strobe(sample_strobe), .update_strobe(update_strobe)
  );

  function automatic int eff_div(bit f, int d);
    if (!f) return (d < 4) ? 4 : d;
    return (d == 0) ? 1 : d;
  endfunction
  function automatic int exp_low(bit f, bit du, int d);
    int e = eff_div(f, d);
    if (!f) return e;
    return du ? 16 * e : 2 * e;
  endfunction
  function automatic int exp_high(bit f, bit du, int d);
    int e = eff_div(f, d);
    if (!f) return e;
    return du ? 9 * e : e;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 off, 1 low, 2 high
  int m_ph, m_cnt, m_rise;
  bit m_seen;
  bit m_q[$];

  function automatic bit m_synced();
    if (SYNC == 0) return (m_ph == 1) ? 1'b0 : ~slave_hold;
    return m_q[SYNC-1];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_rise = 0; m_seen = 0;
      m_q.delete();
      for (int i = 0; i < SYNC; i++) m_q.push_back(1'b1);
    end else begin
      bit sh, line;
      int lo, hi;
      sh = m_synced();
      line = (m_ph == 1) ? 1'b0 : ~slave_hold;
      lo = exp_low(fast_mode, duty_sel, int'(divider));
      hi = exp_high(fast_mode, duty_sel, int'(divider));
      if (!enable) begin
        m_ph = 0; m_cnt = 0; m_rise = 0; m_seen = 0;
      end else if (m_ph == 0) begin
        m_ph = 1; m_cnt = 0;
      end else if (m_ph == 1) begin
        if (m_cnt + 1 >= lo) begin
          m_ph = 2; m_cnt = 0; m_rise = 0; m_seen = 0;
        end else m_cnt++;
      end else begin
        if (m_seen && !sh) begin
          m_ph = 1; m_cnt = 0;
        end else if (sh || m_rise < int'(rise_allow)) begin
          if (!sh) m_rise++;
          if (m_cnt + 1 >= hi) begin m_ph = 1; m_cnt = 0; end
          else m_cnt++;
        end
        if (sh) m_seen = 1;
      end
      if (SYNC > 0) begin
        m_q.push_front(line);
        void'(m_q.pop_back());
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit sh, adv, e_drive, e_samp, e_upd;
      int lo, hi;
      sh = m_synced();
      lo = exp_low(fast_mode, duty_sel, int'(divider));
      hi = exp_high(fast_mode, duty_sel, int'(divider));
      adv = sh || (m_rise < int'(rise_allow));
      e_drive = (m_ph == 1);
      e_samp = (m_ph == 2) && !(m_seen && !sh) && adv && (m_cnt == hi / 2);
      e_upd = (m_ph == 1) && (m_cnt == lo / 4);
      check(scl_drive_low === e_drive, "R1 drive vs model", int'(scl_drive_low), int'(e_drive));
      check(sample_strobe === e_samp, "R9 sample vs model", int'(sample_strobe), int'(e_samp));
      check(update_strobe === e_upd, "R10 update vs model", int'(update_strobe), int'(e_upd));
    end
  end

  task automatic measure(output int lo, output int hi, output int spos,
                         output int upos, output int sc, output int uc);
    lo = 0; hi = 0; spos = -1; upos = -1; sc = 0; uc = 0;
    do @(negedge clk); while (scl_drive_low !== 1'b0);
    do @(negedge clk); while (scl_drive_low !== 1'b1);
    while (scl_drive_low === 1'b1) begin
      if (update_strobe) begin upos = lo; uc++; end
      lo++;
      @(negedge clk);
    end
    while (scl_drive_low === 1'b0) begin
      if (sample_strobe) begin spos = hi; sc++; end
      hi++;
      @(negedge clk);
    end
  endtask

  task automatic configure(bit f, bit du, int d, int r);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    fast_mode = f; duty_sel = du; divider = DIV_W'(d); rise_allow = RISE_W'(r);
    enable = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int lo, hi, sp, up, sc, uc;
    repeat (4) @(negedge clk);
    check(scl_drive_low === 1'b0 && sample_strobe === 1'b0 && update_strobe === 1'b0,
          "R11 reset released", int'(scl_drive_low), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 standard 10
    configure(1'b0, 1'b0, 10, 8);
    @(negedge clk);
    check(scl_drive_low === 1'b1, "R11 starts low", int'(scl_drive_low), 1);
    measure(lo, hi, sp, up, sc, uc);
    check(lo == 10, "R1 low", lo, 10);
    check(hi == 10, "R1 high", hi, 10);
    check(sc == 1 && sp == 5, "R9 sample position", sp, 5);
    check(uc == 1 && up == 2, "R10 update position", up, 2);

    // R11 disable mid low, restart full low
    @(negedge clk);
    while (scl_drive_low !== 1'b1) @(negedge clk);
    repeat (3) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(scl_drive_low === 1'b0, "R11 disabled release", int'(scl_drive_low), 0);
    repeat (3) @(negedge clk);
    enable = 1'b1;
    lo = 0;
    @(negedge clk);
    while (scl_drive_low === 1'b1) begin lo++; @(negedge clk); end
    check(lo == 10, "R11 full low after re-enable", lo, 10);

    // R4 standard clamp
    configure(1'b0, 1'b0, 2, 8);
    measure(lo, hi, sp, up, sc, uc);
    check(lo == 4 && hi == 4, "R4 clamp to 4", lo + hi, 8);

    // R2 fast 2:1
    configure(1'b1, 1'b0, 5, 8);
    measure(lo, hi, sp, up, sc, uc);
    check(lo == 10, "R2 low", lo, 10);
    check(hi == 5, "R2 high", hi, 5);
    check(sp == 2 && up == 2, "R9 R10 fast positions", sp * 10 + up, 22);

    // R3 fast 16:9
    configure(1'b1, 1'b1, 3, 8);
    measure(lo, hi, sp, up, sc, uc);
    check(lo == 48, "R3 low", lo, 48);
    check(hi == 27, "R3 high", hi, 27);

    // R5 fast zero divider
    configure(1'b1, 1'b0, 0, 8);
    measure(lo, hi, sp, up, sc, uc);
    check(lo == 2 && hi == 1, "R5 zero as one", lo * 10 + hi, 21);
    check(sc == 1 && uc == 1, "R9 R10 single strobes min period", sc * 10 + uc, 11);

    // R7 no rise allowance
    configure(1'b0, 1'b0, 10, 0);
    measure(lo, hi, sp, up, sc, uc);
    check(hi == 10 + SYNC, "R7 high with zero allowance", hi, 10 + SYNC);
    check(lo == 10, "R7 low unchanged", lo, 10);

    // R6 slave stretch
    configure(1'b0, 1'b0, 10, 8);
    do @(negedge clk); while (scl_drive_low !== 1'b1);
    while (scl_drive_low === 1'b1) @(negedge clk);
    slave_hold = 1'b1;
    hi = 0;
    while (scl_drive_low === 1'b0) begin
      hi++;
      if (hi == 30) slave_hold = 1'b0;
      @(negedge clk);
    end
    check(hi > 30, "R6 stretched high", hi, 31);

    // R8 other master pulls low early
    configure(1'b0, 1'b0, 20, 8);
    do @(negedge clk); while (scl_drive_low !== 1'b1);
    while (scl_drive_low === 1'b1) @(negedge clk);
    hi = 0;
    while (scl_drive_low === 1'b0) begin
      hi++;
      if (hi == 12) slave_hold = 1'b1;
      @(negedge clk);
    end
    check(hi < 20, "R8 shortened high", hi, 12 + SYNC);
    repeat (3) @(negedge clk);
    slave_hold = 1'b0;
    measure(lo, hi, sp, up, sc, uc);
    check(hi == 20 && lo == 20, "R8 recovers full period", lo + hi, 40);

    enable = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule